// File: doc/BRIEF.md
# Register Port Address Decoder

The block terminates one register port. A requester presents a write or read strobe with a 20-bit byte address, 32-bit write data and a 2-bit length code. It holds that request until it sees ready, then drops the strobes. A small set of local words is answered inside the block: a constant identification word, a constant word giving the counter clock rate, and two scratch registers. A region reserved for per-channel streaming registers is stubbed: it reads as zero and ignores writes.

Every request whose address falls in a fixed upper window is passed straight to a second register port that leads to a downstream client. The address, direction, length code and write data are passed through unchanged. For a forwarded read, the block waits for the client's completion pulse, captures the client's data, and then presents that data with a completion to the requester. Only one forwarded read may be pending at a time. While one is pending, the block holds ready low for every new request.

Top module: `regport_decoder`

## Requirements
- R1: A read of byte address 0x0 completes with the signature word 0x52504443, which is the ASCII text "RPDC" with the first character in the top byte.
- R2: A read of byte address 0xC completes with the constant 175000000 (0x0A6E49C0).
- R3: Byte addresses 0x10 and 0x14 are two independent scratch registers. Each reads back the last value written to it and is unaffected by writes to any other address. Both read as zero after reset.
- R4: A request whose address lies in 0x40000 to 0x7FFFC inclusive appears on the downstream port in the same cycle. It carries the same address, the same write or read strobe, the same length code and, for writes, the same data. A request outside that window never raises a downstream strobe.
- R5: For a forwarded read, the requester's read-complete rises exactly one cycle after the cycle in which the client's read-complete is high. The returned data equals the client's data, and there is no requester completion before the client's.
- R6: From the acceptance of a forwarded read until its completion reaches the requester, ready stays low for every request, whether local or forwarded.
- R7: When no forwarded read is pending, a local request is accepted at once, whatever the downstream ready is. A local read's read-complete is high in exactly the one cycle after the accepting edge.
- R8: Reads of unmapped local addresses, including the stubbed streaming region 0x200 to 0x5FC, complete with data zero. Writes there change no readable state.
- R9: A forwarded request is accepted (ready high) exactly when no forwarded read is pending and the downstream ready is high. A forwarded write produces no requester completion.
- R10: After reset, read-complete is low, ready is high for a local request, and no downstream strobe is raised while no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_wr | input | 1 | Requester write strobe |
| up_rd | input | 1 | Requester read strobe |
| up_addr | input | 20 | Requester byte address |
| up_wdata | input | 32 | Requester write data |
| up_len | input | 2 | Requester length code (2'b10 = 32-bit) |
| up_rdata | output | 32 | Read data returned to requester |
| up_rc | output | 1 | Read-complete to requester |
| up_rdy | output | 1 | Request accepted at this edge when high |
| dn_wr | output | 1 | Downstream write strobe |
| dn_rd | output | 1 | Downstream read strobe |
| dn_addr | output | 20 | Downstream byte address |
| dn_wdata | output | 32 | Downstream write data |
| dn_len | output | 2 | Downstream length code |
| dn_rdata | input | 32 | Client read data |
| dn_rc | input | 1 | Client read-complete pulse |
| dn_rdy | input | 1 | Client ready |

## Verification
Several properties are checked on every cycle. Local reads complete one cycle after acceptance. Scratch words hold when not written. A forwarded completion is always preceded by the client's pulse while a read is pending. The local and forwarded completions never coincide. Downstream strobes occur only for addresses inside the window. Only the bench's scenarios show the following: the actual constant and scratch values, that a write to an unmapped or stubbed address leaves the scratch words intact, that ready stays low for a local request queued behind a slow client, and that acceptance of a forwarded request tracks the client's ready.

// File: rtl/rp_pkg.sv
// Shared definitions for the register port decoder.
// Assumes byte addressing with 32-bit words; addresses are compared whole.
package rp_pkg;
    // Source of a completed read returned to the requester
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_LOCAL = 2'd1,
        SRC_FWD   = 2'd2
    } rd_src_e;
endpackage

// File: rtl/rp_dma_stub.sv
// Stand-in for the per-channel streaming register region.
// Decodes its address range; reads return zero, writes are discarded.
// Assumes the caller only consults rdata when hit is high.
module rp_dma_stub #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] LO = 20'h00200,
    parameter logic [ADDR_W-1:0] HI = 20'h005FC
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [DATA_W-1:0] rdata
);
    // Range decode and constant-zero data
    always_comb begin
        hit   = (addr >= LO) && (addr <= HI);
        rdata = '0;
    end
endmodule

// File: rtl/rp_local_regs.sv
// Local register file: signature, counter frequency, two scratch words,
// plus the stubbed streaming region. Reads complete one cycle after the
// accepting edge with registered data. Assumes rd_acc/wr_acc are only
// raised for addresses outside the forwarding window.
module rp_local_regs #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] SIG_WORD  = 32'h52504443,
    parameter logic [DATA_W-1:0] FREQ_WORD = 32'd175000000,
    parameter logic [ADDR_W-1:0] SIG_ADDR  = 20'h00000,
    parameter logic [ADDR_W-1:0] FREQ_ADDR = 20'h0000C,
    parameter logic [ADDR_W-1:0] SCR0_ADDR = 20'h00010,
    parameter logic [ADDR_W-1:0] SCR1_ADDR = 20'h00014
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic              rd_acc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              rc_q,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] scr0, scr1;
    logic [DATA_W-1:0] lookup;
    logic              stub_hit;
    logic [DATA_W-1:0] stub_data;

    rp_dma_stub #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stub (
        .addr  (addr),
        .hit   (stub_hit),
        .rdata (stub_data)
    );

    // Read data selection for the presented address
    always_comb begin
        if (stub_hit)                lookup = stub_data;
        else if (addr == SIG_ADDR)   lookup = SIG_WORD;
        else if (addr == FREQ_ADDR)  lookup = FREQ_WORD;
        else if (addr == SCR0_ADDR)  lookup = scr0;
        else if (addr == SCR1_ADDR)  lookup = scr1;
        else                         lookup = '0;
    end

    // Scratch register updates on accepted writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr0 <= '0;
            scr1 <= '0;
        end else if (wr_acc) begin
            if (addr == SCR0_ADDR) scr0 <= wdata;
            if (addr == SCR1_ADDR) scr1 <= wdata;
        end
    end

    // Registered read completion and data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rc_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            rc_q <= rd_acc;
            if (rd_acc) rdata_q <= lookup;
        end
    end

    // R7
    local_rc_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rc_q);

    // R3
    scr0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && addr == SCR0_ADDR) |=> $stable(scr0));

    // R3
    scr1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && addr == SCR1_ADDR) |=> $stable(scr1));
endmodule

// File: rtl/rp_fwd_ctrl.sv
// Pass-through controller for the downstream client port.
// Presents in-window requests unchanged downstream, tracks one pending
// forwarded read and returns the client's data one cycle after its
// completion pulse. Assumes the client pulses dn_rc only for a read it
// has accepted.
module rp_fwd_ctrl #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic              in_win,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LEN_W-1:0]  len,
    input  logic              dn_rdy,
    input  logic              dn_rc,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              dn_wr,
    output logic              dn_rd,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [LEN_W-1:0]  dn_len,
    output logic              busy,
    output logic              fwd_rdy,
    output logic              rc_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Downstream request presentation, gated while a read is pending
    always_comb begin
        dn_wr    = req_wr && in_win && !busy;
        dn_rd    = req_rd && in_win && !busy;
        dn_addr  = addr;
        dn_wdata = wdata;
        dn_len   = len;
        fwd_rdy  = !busy && dn_rdy;
    end

    // Pending-read tracking and completion return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            rc_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            rc_q <= 1'b0;
            if (busy) begin
                if (dn_rc) begin
                    busy    <= 1'b0;
                    rc_q    <= 1'b1;
                    rdata_q <= dn_rdata;
                end
            end else if (dn_rd && dn_rdy) begin
                busy <= 1'b1;
            end
        end
    end

    // R5
    fwd_rc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rc_q |-> ($past(dn_rc) && $past(busy)));

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(dn_rd) && $past(dn_rdy)));
endmodule

// File: rtl/regport_decoder.sv
// Register port decoder top level.
// Splits requester traffic between the local register file and the
// downstream pass-through window, and merges the two completion paths.
// Assumes the requester holds a request until ready and then drops it.
module regport_decoder #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 2,
    parameter logic [ADDR_W-1:0] WIN_LO = 20'h40000,
    parameter logic [ADDR_W-1:0] WIN_HI = 20'h7FFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_wr,
    input  logic              up_rd,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [DATA_W-1:0] up_wdata,
    input  logic [LEN_W-1:0]  up_len,
    output logic [DATA_W-1:0] up_rdata,
    output logic              up_rc,
    output logic              up_rdy,
    output logic              dn_wr,
    output logic              dn_rd,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [DATA_W-1:0] dn_wdata,
    output logic [LEN_W-1:0]  dn_len,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_rc,
    input  logic              dn_rdy
);
    import rp_pkg::*;

    logic              in_win, busy, fwd_rdy, acc;
    logic              loc_wr_acc, loc_rd_acc;
    logic              loc_rc, fwd_rc;
    logic [DATA_W-1:0] loc_rdata, fwd_rdata;
    rd_src_e           src;

    // Window decode and acceptance
    always_comb begin
        in_win     = (up_addr >= WIN_LO) && (up_addr <= WIN_HI);
        up_rdy     = in_win ? fwd_rdy : !busy;
        acc        = (up_wr || up_rd) && up_rdy;
        loc_wr_acc = acc && up_wr && !in_win;
        loc_rd_acc = acc && up_rd && !in_win;
    end

    rp_local_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_local (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_acc  (loc_wr_acc),
        .rd_acc  (loc_rd_acc),
        .addr    (up_addr),
        .wdata   (up_wdata),
        .rc_q    (loc_rc),
        .rdata_q (loc_rdata)
    );

    rp_fwd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_wr   (up_wr),
        .req_rd   (up_rd),
        .in_win   (in_win),
        .addr     (up_addr),
        .wdata    (up_wdata),
        .len      (up_len),
        .dn_rdy   (dn_rdy),
        .dn_rc    (dn_rc),
        .dn_rdata (dn_rdata),
        .dn_wr    (dn_wr),
        .dn_rd    (dn_rd),
        .dn_addr  (dn_addr),
        .dn_wdata (dn_wdata),
        .dn_len   (dn_len),
        .busy     (busy),
        .fwd_rdy  (fwd_rdy),
        .rc_q     (fwd_rc),
        .rdata_q  (fwd_rdata)
    );

    // Completion merge toward the requester
    always_comb begin
        if (loc_rc)      src = SRC_LOCAL;
        else if (fwd_rc) src = SRC_FWD;
        else             src = SRC_NONE;
        case (src)
            SRC_LOCAL: up_rdata = loc_rdata;
            SRC_FWD:   up_rdata = fwd_rdata;
            default:   up_rdata = '0;
        endcase
        up_rc = (src != SRC_NONE);
    end

    // R5
    rc_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_rc && fwd_rc));

    // R4
    dn_strobe_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_wr || dn_rd) |-> (up_addr >= WIN_LO && up_addr <= WIN_HI));
endmodule

// File: tb/sim_regport_decoder.sv
module sim_regport_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_wr = 1'b0, up_rd = 1'b0;
    logic [19:0] up_addr = '0;
    logic [31:0] up_wdata = '0;
    logic [1:0]  up_len = 2'b10;
    logic [31:0] up_rdata;
    logic        up_rc, up_rdy;
    logic        dn_wr, dn_rd;
    logic [19:0] dn_addr;
    logic [31:0] dn_wdata;
    logic [1:0]  dn_len;
    logic [31:0] dn_rdata = '0;
    logic        dn_rc = 1'b0;
    logic        dn_rdy = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    regport_decoder u0 (.*);

    // reference model state
    logic [31:0] m_scr0 = 0, m_scr1 = 0, m_rdata = 0;
    bit m_busy = 0, m_rc = 0;

    function automatic bit in_win(logic [19:0] a);
        return (a >= 20'h40000) && (a <= 20'h7FFFC);
    endfunction

    function automatic logic [31:0] local_value(logic [19:0] a);
        if (a == 20'h0)  return 32'h52504443;
        if (a == 20'hC)  return 32'd175000000;
        if (a == 20'h10) return m_scr0;
        if (a == 20'h14) return m_scr1;
        return 32'h0;
    endfunction

    function automatic bit exp_rdy();
        if (m_busy) return 1'b0;
        return in_win(up_addr) ? dn_rdy : 1'b1;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // model update at each edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_scr0 = 0; m_scr1 = 0; m_busy = 0; m_rc = 0; m_rdata = 0;
        end else begin
            bit acc;
            acc = (up_wr || up_rd) && exp_rdy();
            m_rc = 0;
            if (m_busy && dn_rc) begin
                m_rc = 1; m_rdata = dn_rdata; m_busy = 0;
            end else if (acc && up_rd && !in_win(up_addr)) begin
                m_rc = 1; m_rdata = local_value(up_addr);
            end else if (acc && up_rd && in_win(up_addr)) begin
                m_busy = 1;
            end
            if (acc && up_wr && !in_win(up_addr)) begin
                if (up_addr == 20'h10) m_scr0 = up_wdata;
                if (up_addr == 20'h14) m_scr1 = up_wdata;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit fw;
            fw = in_win(up_addr) && !m_busy;
            chk("R5/R7 up_rc", {31'b0, up_rc}, {31'b0, m_rc});
            if (m_rc) chk("R1/R2/R3/R5/R8 up_rdata", up_rdata, m_rdata);
            chk("R6/R9 up_rdy", {31'b0, up_rdy}, {31'b0, exp_rdy()});
            chk("R4 dn_wr", {31'b0, dn_wr}, {31'b0, up_wr && fw});
            chk("R4 dn_rd", {31'b0, dn_rd}, {31'b0, up_rd && fw});
            if (dn_wr || dn_rd) begin
                chk("R4 dn_addr", {12'b0, dn_addr}, {12'b0, up_addr});
                chk("R4 dn_len", {30'b0, dn_len}, {30'b0, up_len});
                if (dn_wr) chk("R4 dn_wdata", dn_wdata, up_wdata);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // present a request and wait for acceptance
    task automatic issue(bit w, bit r, logic [19:0] a, logic [31:0] d);
        @(posedge clk); #1;
        up_wr = w; up_rd = r; up_addr = a; up_wdata = d; up_len = 2'b10;
        forever begin
            @(negedge clk);
            if (up_rdy) break;
        end
        @(posedge clk); #1;
        up_wr = 0; up_rd = 0;
    endtask

    // local read, returning data and latency in cycles
    task automatic local_read(logic [19:0] a, output logic [31:0] d, output int lat);
        issue(0, 1, a, 0);
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!up_rc && lat < 50);
        d = up_rdata;
    endtask

    // forwarded read with client answering after dly cycles
    task automatic fwd_read(logic [19:0] a, logic [31:0] cd, int dly,
                            output logic [31:0] d, output int early);
        issue(0, 1, a, 0);
        early = 0;
        repeat (dly) begin
            @(negedge clk);
            if (up_rc) early++;
        end
        @(posedge clk); #1;
        dn_rc = 1; dn_rdata = cd;
        @(posedge clk); #1;
        dn_rc = 0; dn_rdata = 0;
        @(negedge clk);
        d = up_rc ? up_rdata : 32'hFFFF_FFFF;
    endtask

    initial begin
        logic [31:0] d;
        int lat, early, low_cnt;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 up_rc after reset", {31'b0, up_rc}, 32'd0);
        chk("R10 up_rdy after reset", {31'b0, up_rdy}, 32'd1);
        chk("R10 dn strobes after reset", {30'b0, dn_wr, dn_rd}, 32'd0);
        @(posedge clk); #1; rst_n = 1;

        local_read(20'h0, d, lat);
        chk("R1 signature", d, 32'h52504443);
        chk("R7 local read latency", lat, 1);
        local_read(20'hC, d, lat);
        chk("R2 frequency word", d, 32'd175000000);

        issue(1, 0, 20'h10, 32'h0000DEAD);
        issue(1, 0, 20'h14, 32'h0000BEEF);
        local_read(20'h14, d, lat);
        chk("R3 scratch1", d, 32'h0000BEEF);
        local_read(20'h10, d, lat);
        chk("R3 scratch0", d, 32'h0000DEAD);

        // R8 unmapped and stub writes/reads
        issue(1, 0, 20'h204, 32'h11111111);
        issue(1, 0, 20'h18, 32'h22222222);
        local_read(20'h204, d, lat);
        chk("R8 stub reads zero", d, 0);
        local_read(20'h18, d, lat);
        chk("R8 unmapped reads zero", d, 0);
        local_read(20'h10, d, lat);
        chk("R8 scratch0 untouched", d, 32'h0000DEAD);

        // R7 local accepted while client not ready
        dn_rdy = 0;
        local_read(20'h14, d, lat);
        chk("R7 local ignores dn_rdy", lat, 1);

        // R9 forwarded write waits for client ready
        fork
            issue(1, 0, 20'h7FFFC, 32'h00001357);
            begin
                repeat (4) @(posedge clk);
                #1 dn_rdy = 1;
            end
        join
        issue(1, 0, 20'h40000, 32'h12345678);
        repeat (2) @(negedge clk);
        chk("R9 no completion on write", {31'b0, up_rc}, 0);

        // R5 forwarded reads
        fwd_read(20'h40000, 32'hACE0BA51, 3, d, early);
        chk("R5 forwarded data 1", d, 32'hACE0BA51);
        chk("R5 no early completion", early, 0);
        fwd_read(20'h60000, 32'hACE0BA53, 0, d, early);
        chk("R5 forwarded data 2", d, 32'hACE0BA53);

        // R6 local request blocked behind pending forwarded read
        issue(0, 1, 20'h7FFFC, 0);
        @(posedge clk); #1;
        up_rd = 1; up_addr = 20'h0;
        low_cnt = 0;
        repeat (5) begin
            @(negedge clk);
            if (!up_rdy) low_cnt++;
        end
        chk("R6 ready held low", low_cnt, 5);
        @(posedge clk); #1 dn_rc = 1; dn_rdata = 32'hACE0BA52;
        @(posedge clk); #1 dn_rc = 0;
        @(negedge clk);
        chk("R5 pending read data", up_rdata, 32'hACE0BA52);
        chk("R6 ready back", {31'b0, up_rdy}, 1);
        @(posedge clk); #1 up_rd = 0;
        @(negedge clk);
        chk("R1 queued signature read", up_rdata, 32'h52504443);

        repeat (5) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule